// File: doc/BRIEF.md
# Configurable UART Frame Serializer

This block is the transmit half of an asynchronous serial port, reduced to the shifter. It takes a word of 7, 8 or 9 bits together with a start strobe, builds a frame and clocks it out on a single TX line, one bit per pulse of an external baud tick. A busy flag tells the caller when a new word may be offered. Baud generation, queuing and reception belong to neighbouring blocks.

Three independent options shape the line. The bit-order option picks whether the lowest or the highest data bit follows the start bit. The data-inversion option sends data and parity in negative logic while leaving start and stop alone. The pin-inversion option flips every level on the wire, idle included, so an external inverter can sit on the line. These options, along with word length and parity mode, sit in a configuration register that only accepts writes while the enable input is low.

A frame is accepted when enable is high, busy is low and the start strobe is sampled. The line stays idle until the next baud tick, which opens the start bit; each further tick moves to the next bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, with pin inversion at its reset value of 0, tx is 1 and busy is 0.
- R2: A frame is one start bit (logic 0), the data bits, a parity bit if parity is enabled, then one stop bit (logic 1). Between acceptance and the first baud tick the line stays idle; each baud tick starts the next bit, and the tick after the stop bit returns the line to idle.
- R3: With cfg_msb_first at 0, data bit 0 is the first bit after the start bit, then bit 1 and upward.
- R4: With cfg_msb_first at 1, the highest bit of the word is sent first. cfg_wlen selects the word length: 0 is 7 bits, 1 is 8 bits, 2 and 3 are 9 bits; data bits above the word length are not sent.
- R5: With cfg_data_inv at 1, every data bit is sent inverted and the parity bit is computed on the inverted data; start and stop levels are unchanged.
- R6: With cfg_par_en at 1, the parity bit follows the last data bit, and the number of ones among the sent data bits and the parity bit is even when cfg_par_odd is 0 and odd when cfg_par_odd is 1.
- R7: With cfg_pin_inv at 1, every level on tx is inverted, including idle (tx reads 0 when idle).
- R8: The configuration register loads on cfg_we only while enable is 0; a write attempted while enable is 1 has no effect.
- R9: busy is 1 from the clock edge that accepts a start strobe until the baud tick that ends the stop bit.
- R10: A start strobe is ignored while busy is 1 or while enable is 0.
- R11: While enable is 0, tx holds the idle level (1 XOR pin inversion) and busy is 0; dropping enable mid-frame abandons the frame.
- R12: Baud ticks while no frame is pending have no effect on tx or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module enable; configuration is writable only while low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_msb_first | input | 1 | 1: highest data bit first |
| cfg_data_inv | input | 1 | 1: data and parity sent in negative logic |
| cfg_pin_inv | input | 1 | 1: whole line inverted |
| cfg_wlen | input | 2 | Word length code (0: 7, 1: 8, 2/3: 9 bits) |
| cfg_par_en | input | 1 | 1: append parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| data | input | 9 | Word to send, sampled on acceptance |
| start | input | 1 | Start strobe |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| tx | output | 1 | Serial line |
| busy | output | 1 | Frame pending or in progress |

## Verification
The bench goes after the places where the three options interact: a design that reversed the whole 9-bit field instead of the selected word would shift the first bits of 7- and 8-bit words in MSB-first mode, and one that inverted start and stop under data inversion, or computed parity before inverting, would break framing or give the wrong parity on 7- and 9-bit words. It writes configuration while enabled to catch a missing lock, and with pin inversion set it checks the idle level as well as the frame. It also offers a second start strobe mid-frame, ticks an idle line, and drops enable mid-frame, where a faulty design would restart, drift or leave busy stuck high.

// File: rtl/uft_pkg.sv
// uft_pkg: shared constants and types for the UART frame serializer.
// Assumes a word of at most MAX_DATA_W bits plus one parity bit.
package uft_pkg;

    localparam int unsigned MAX_DATA_W = 9;
    localparam int unsigned PAYLOAD_W  = MAX_DATA_W + 1;
    localparam int unsigned FRAME_MAX  = PAYLOAD_W + 2;
    localparam int unsigned IDX_W      = $clog2(FRAME_MAX);
    localparam int unsigned LEN_W      = $clog2(MAX_DATA_W + 1);

    // Word length encodings; code 3 behaves as 9 bits.
    typedef enum logic [1:0] {
        WLEN_7  = 2'd0,
        WLEN_8  = 2'd1,
        WLEN_9  = 2'd2,
        WLEN_9B = 2'd3
    } wlen_e;

    typedef struct packed {
        logic  msb_first;
        logic  data_inv;
        logic  pin_inv;
        wlen_e wlen;
        logic  par_en;
        logic  par_odd;
    } frame_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;

    // Number of data bits for a length code.
    function automatic logic [LEN_W-1:0] wlen_bits(wlen_e w);
        case (w)
            WLEN_7:  return LEN_W'(7);
            WLEN_8:  return LEN_W'(8);
            default: return LEN_W'(9);
        endcase
    endfunction

endpackage

// File: rtl/uft_cfg_reg.sv
// uft_cfg_reg: holds the frame options. Loads only while the module is
// disabled, so options never change under a frame in flight.
// Assumes a synchronous active-low reset; reset clears every option.
module uft_cfg_reg
    import uft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       we,
    input  frame_cfg_t cfg_in,
    output frame_cfg_t cfg_q
);

    // Option register with write lock while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we && !enable) begin
            cfg_q <= cfg_in;
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(cfg_q)); // R8

endmodule

// File: rtl/uft_word_build.sv
// uft_word_build: turns the held word into the payload in send order.
// Masks to the word length, applies data inversion, reorders for
// MSB-first, then places parity (computed on the inverted data) just
// above the last data bit. Payload bit 0 goes on the line first.
// Purely combinational; assumes cfg is stable while a frame runs.
module uft_word_build
    import uft_pkg::*;
(
    input  frame_cfg_t             cfg,
    input  logic [MAX_DATA_W-1:0]  word,
    output logic [PAYLOAD_W-1:0]   payload,
    output logic [IDX_W-1:0]       payload_n
);

    logic [LEN_W-1:0]      nbits;
    logic [LEN_W-1:0]      shamt;
    logic [MAX_DATA_W-1:0] mask;
    logic [MAX_DATA_W-1:0] pol;
    logic [MAX_DATA_W-1:0] rev;
    logic [MAX_DATA_W-1:0] ordered;
    logic                  parity;

    // Word length and the shift that aligns a reversed word to bit 0.
    always_comb begin
        nbits = wlen_bits(cfg.wlen);
        shamt = LEN_W'(MAX_DATA_W) - nbits;
    end

    // Per-bit mask and full-width reversal, one slice per bit.
    for (genvar g = 0; g < MAX_DATA_W; g++) begin : g_bit
        assign mask[g] = (LEN_W'(g) < nbits);
        assign rev[g]  = pol[MAX_DATA_W-1-g];
    end

    // Inversion applied inside the word only.
    always_comb begin
        pol = (word ^ {MAX_DATA_W{cfg.data_inv}}) & mask;
    end

    // Order select, parity and payload assembly.
    always_comb begin
        ordered   = cfg.msb_first ? (rev >> shamt) : pol;
        parity    = (^pol) ^ cfg.par_odd;
        payload   = {1'b0, ordered};
        if (cfg.par_en) begin
            payload = payload | (PAYLOAD_W'(parity) << nbits);
        end
        payload_n = IDX_W'(nbits) + IDX_W'(cfg.par_en);
    end

    // Parity bit and sent data carry the selected parity in total.
    always_comb begin
        if (cfg.par_en) begin
            AST_PARITY_SENSE: assert ((^payload) == cfg.par_odd); // R6
        end
    end

endmodule

// File: rtl/uft_frame_seq.sv
// uft_frame_seq: frame sequencer. Accepts a start strobe when idle,
// waits for the first baud tick, then walks start, payload and stop
// bits one tick each. Produces the un-inverted line level and busy.
// Assumes baud_tick is a one-cycle pulse; dropping enable aborts.
module uft_frame_seq
    import uft_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  start,
    input  logic                  tick,
    input  logic [MAX_DATA_W-1:0] data,
    input  logic [PAYLOAD_W-1:0]  payload,
    input  logic [IDX_W-1:0]      payload_n,
    output logic [MAX_DATA_W-1:0] word_q,
    output logic                  line_q,
    output logic                  busy
);

    tx_state_e        state_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;

    // Index of the stop bit within the frame.
    always_comb begin
        last_idx = payload_n + IDX_W'(1);
        busy     = (state_q != ST_IDLE);
    end

    // Frame state, bit index, held word and raw line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            line_q  <= 1'b1;
            word_q  <= '0;
        end else if (!enable) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            line_q  <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        word_q  <= data;
                        state_q <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (tick) begin
                        state_q <= ST_SEND;
                        idx_q   <= '0;
                        line_q  <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (idx_q == last_idx) begin
                            state_q <= ST_IDLE;
                            idx_q   <= '0;
                            line_q  <= 1'b1;
                        end else begin
                            idx_q  <= idx_q + IDX_W'(1);
                            line_q <= (idx_q < payload_n) ? payload[idx_q] : 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    line_q  <= 1'b1;
                end
            endcase
        end
    end

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start && !busy) |=> busy); // R9

    AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_ARM && tick) |=> (line_q == 1'b0)); // R2

    AST_STOP_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_SEND && tick && idx_q == last_idx)
            |=> (line_q && !busy)); // R2

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(line_q)); // R12

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (line_q && !busy)); // R11

    AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && busy) |=> $stable(word_q)); // R10

endmodule

// File: rtl/uart_frame_tx.sv
// uart_frame_tx: UART transmit serializer with selectable bit order,
// data/parity inversion and whole-line inversion. Options are locked
// while enable is high. Assumes an external one-cycle baud_tick.
module uart_frame_tx
    import uft_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  cfg_we,
    input  logic                  cfg_msb_first,
    input  logic                  cfg_data_inv,
    input  logic                  cfg_pin_inv,
    input  logic [1:0]            cfg_wlen,
    input  logic                  cfg_par_en,
    input  logic                  cfg_par_odd,
    input  logic [MAX_DATA_W-1:0] data,
    input  logic                  start,
    input  logic                  baud_tick,
    output logic                  tx,
    output logic                  busy
);

    frame_cfg_t            cfg_in;
    frame_cfg_t            cfg_q;
    logic [MAX_DATA_W-1:0] word_q;
    logic [PAYLOAD_W-1:0]  payload;
    logic [IDX_W-1:0]      payload_n;
    logic                  line_q;

    // Gather the option pins into one record.
    always_comb begin
        cfg_in.msb_first = cfg_msb_first;
        cfg_in.data_inv  = cfg_data_inv;
        cfg_in.pin_inv   = cfg_pin_inv;
        cfg_in.wlen      = wlen_e'(cfg_wlen);
        cfg_in.par_en    = cfg_par_en;
        cfg_in.par_odd   = cfg_par_odd;
    end

    uft_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .we     (cfg_we),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    uft_word_build u_build (
        .cfg       (cfg_q),
        .word      (word_q),
        .payload   (payload),
        .payload_n (payload_n)
    );

    uft_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start     (start),
        .tick      (baud_tick),
        .data      (data),
        .payload   (payload),
        .payload_n (payload_n),
        .word_q    (word_q),
        .line_q    (line_q),
        .busy      (busy)
    );

    // Line polarity applied last, so idle, start and stop follow it.
    always_comb begin
        tx = line_q ^ cfg_q.pin_inv;
    end

    AST_IDLE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (busy || tx == !cfg_q.pin_inv)); // R7

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_data_inv = 1'b0;
    logic       cfg_pin_inv = 1'b0;
    logic [1:0] cfg_wlen = 2'd1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [8:0] data = '0;
    logic       start = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx;
    logic       busy;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    uart_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .cfg_msb_first(cfg_msb_first), .cfg_data_inv(cfg_data_inv),
        .cfg_pin_inv(cfg_pin_inv), .cfg_wlen(cfg_wlen),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .data(data), .start(start), .baud_tick(baud_tick),
        .tx(tx), .busy(busy)
    );

    // Vector: [19]msb [18]dinv [17]pinv [16:15]wlen [14]par_en [13]par_odd
    //         [12:4]data [3:0]expected frame length in bits
    localparam int NVEC = 10;
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 9'h0A5, 4'd10},
        {1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 9'h0A5, 4'd10},
        {1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 9'h041, 4'd9},
        {1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 9'h10F, 4'd12},
        {1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 9'h1FF, 4'd12},
        {1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 9'h0F1, 4'd11},
        {1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 9'h055, 4'd10},
        {1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 9'h03C, 4'd10},
        {1'b1, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 9'h0C3, 4'd11},
        {1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 9'h17F, 4'd10}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R3";
            1, 2, 3: return "R4";
            4, 9: return "R6";
            5, 6: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected line levels, index 0 = start bit, from the requirements.
    function automatic logic [11:0] model(logic [19:0] v, output int n);
        logic [11:0] f;
        logic [8:0]  w;
        int          len;
        logic        par;
        f   = '0;
        len = (v[16:15] == 2'd0) ? 7 : (v[16:15] == 2'd1) ? 8 : 9;
        w   = v[12:4];
        if (v[18]) w = ~w;
        par = v[13];
        f[0] = 1'b0;
        for (int i = 0; i < len; i++) begin
            f[1+i] = v[19] ? w[len-1-i] : w[i];
            par    = par ^ w[i];
        end
        n = len + 1;
        if (v[14]) begin
            f[n] = par;
            n++;
        end
        f[n] = 1'b1;
        n++;
        if (v[17]) f = ~f;
        return f;
    endfunction

    task automatic write_cfg(logic [19:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_msb_first = v[19];
        cfg_data_inv = v[18];
        cfg_pin_inv = v[17];
        cfg_wlen = v[16:15];
        cfg_par_en = v[14];
        cfg_par_odd = v[13];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic tick_pulse();
        @(negedge clk);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe(logic [8:0] d);
        @(negedge clk);
        start = 1'b1;
        data = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [11:0] f;
        logic [11:0] g;
        int          n;
        int          ones;
        repeat (3) @(negedge clk);
        chk("R1 tx", int'(tx), 1);
        chk("R1 busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of vectors walked by one loop.
        for (int i = 0; i < NVEC; i++) begin
            enable = 1'b0;
            write_cfg(VEC[i]);
            enable = 1'b1;
            f = model(VEC[i], n);
            chk("R2 length", n, int'(VEC[i][3:0]));
            chk("R7 idle", int'(tx), int'(!VEC[i][17]));
            strobe(VEC[i][12:4]);
            chk("R9 busy on accept", int'(busy), 1);
            chk("R2 idle before tick", int'(tx), int'(!VEC[i][17]));
            g = '0;
            for (int k = 0; k < n; k++) begin
                tick_pulse();
                g[k] = tx;
                chk(vec_tag(i), int'(tx), int'(f[k]));
                chk("R9 busy in frame", int'(busy), 1);
            end
            if (VEC[i][14]) begin
                ones = 0;
                for (int k = 1; k < n - 1; k++) ones += int'(g[k] ^ VEC[i][17]);
                chk("R6 parity sense", ones % 2, int'(VEC[i][13]));
            end
            tick_pulse();
            chk("R9 busy after stop", int'(busy), 0);
            chk("R2 idle after stop", int'(tx), int'(!VEC[i][17]));
        end

        // R8: write while enabled is ignored (pin inversion would flip idle).
        enable = 1'b1;
        write_cfg({1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 9'h0, 4'd0});
        enable = 1'b0;
        write_cfg({1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 9'h0, 4'd0});
        enable = 1'b1;
        write_cfg({1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 9'h0, 4'd0});
        @(negedge clk);
        chk("R8 locked write", int'(tx), 1);

        // R11: disabled with pin inversion holds inverted idle; R10 start ignored.
        enable = 1'b0;
        write_cfg({1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 9'h0, 4'd0});
        chk("R11 disabled idle", int'(tx), 0);
        strobe(9'h0AA);
        chk("R10 start while disabled", int'(busy), 0);
        tick_pulse();
        chk("R11 tick while disabled", int'(tx), 0);

        // R12: ticks on an idle enabled line do nothing.
        write_cfg({1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 9'h0, 4'd0});
        enable = 1'b1;
        tick_pulse();
        tick_pulse();
        chk("R12 idle tick tx", int'(tx), 1);
        chk("R12 idle tick busy", int'(busy), 0);

        // R10: second strobe mid-frame neither alters nor restarts the frame.
        f = model({1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 9'h0F0, 4'd0}, n);
        strobe(9'h0F0);
        for (int k = 0; k < n; k++) begin
            tick_pulse();
            if (k == 2) strobe(9'h00F);
            chk("R10 frame kept", int'(tx), int'(f[k]));
        end
        tick_pulse();
        chk("R10 no restart", int'(busy), 0);
        tick_pulse();
        chk("R10 line idle", int'(tx), 1);

        // R11: dropping enable mid-frame abandons it.
        strobe(9'h000);
        tick_pulse();
        tick_pulse();
        chk("R11 mid-frame low", int'(tx), 0);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R11 abort busy", int'(busy), 0);
        chk("R11 abort tx", int'(tx), 1);
        enable = 1'b1;
        tick_pulse();
        chk("R11 stays idle", int'(busy), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule